// File: doc/BRIEF.md
# ROM Data Port Address Generator

This block lets a byte-wide host bus stream bytes out of an external read-only memory without the host computing addresses itself. The host loads a 24-bit base pointer, a 16-bit offset and a 16-bit step, one byte at a time, and then selects an addressing behaviour through a mode byte. Each read of the streaming port fetches one memory byte and advances either the pointer or the offset. Each read of the peek port fetches the byte at pointer plus offset and can, in one mode, fold the offset into the pointer or double it. Writing the two offset bytes can also make the pointer jump by the offset.

The host side is one strobe (`bus_sel`) with a write qualifier, a register index and write data. A read returns its byte in `rdata` on the clock edge that ends the strobe cycle. During a port read the block drives the memory address combinationally and raises `mem_req`. The memory returns `mem_rdata` in the same cycle. Every address leaves the block after one fold into a data region of run-time size `region_size`, and then gets a fixed base added.

Top module: `romport_agen`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `rdata` is 0, and no pointer byte counts as written.
- R2: Until each of the three pointer bytes (register indices 2, 3, 4, least significant first) has been written at least once, a read of the streaming port (index 0) or the peek port (index 1) returns 0, raises no `mem_req` and changes no state.
- R3: A write to the mode register (index 9) takes effect only when all three pointer bytes have been written. An accepted write clears both offset-byte-written latches.
- R4: On a streaming read with mode bit 1 set, the address is pointer plus offset, and the offset then increases by 1. The offset is sign-extended when mode bit 3 is set. The pointer is unchanged.
- R5: On a streaming read with mode bit 1 clear, the address is the pointer. The increment is the step register (indices 7, 8, low byte first) when mode bit 0 is set, otherwise 1. It is sign-extended when mode bit 2 is set. It is added to the pointer when mode bit 4 is clear and to the offset (indices 5, 6, low byte first) when bit 4 is set.
- R6: A peek read addresses pointer plus offset, sign-extended per mode bit 3. Only when mode bits 6:5 are 11 does it change state: the pointer takes that sum when bit 4 is clear, and the offset doubles when bit 4 is set.
- R7: When an offset-byte write leaves both offset-byte latches set, and mode bit 1 is set and bit 4 is clear, the pointer jumps. With bits 6:5 = 01 it adds the new low offset byte, sign-extended from 8 bits if bit 3 is set. With bits 6:5 = 10 it adds the new 16-bit offset, sign-extended if bit 3 is set.
- R8: The memory address is A minus `region_size` if A is not below `region_size`, otherwise A, plus the base 0x100000.
- R9: The register indices 2 to 9 read back their stored byte. Any other unused index reads 0.
- R10: Pointer arithmetic wraps at 24 bits. Offset arithmetic wraps at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read for the current strobe |
| bus_reg | input | 4 | Register index |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid after the strobe's clock edge |
| mem_req | output | 1 | Memory fetch in this cycle |
| mem_addr | output | 24 | Folded memory address |
| mem_rdata | input | 8 | Byte returned by memory in the same cycle |
| region_size | input | 24 | Size of the data region used for the fold |

## Verification
The bench builds the block with its default widths: a 24-bit pointer, a 16-bit offset and step, and a 0x100000 base. It ties `region_size` to 0x200000. With these values a pointer of 0xFFFFFF reaches the 24-bit wrap, an offset of 0xFFFF reaches the 16-bit wrap, and pointers above 0x200000 take the fold branch while pointers below it do not. The memory model returns a byte derived from the address, so each port read is checked both on `mem_addr` and on the byte returned.

// File: rtl/romport_pkg.sv
// Shared definitions for the ROM data port address generator.
// Assumes the mode byte layout below is fixed; the bit positions are decoded
// by the stepping and jump logic.
package romport_pkg;

    typedef struct packed {
        logic       spare;     // bit 7, stored and read back only
        logic [1:0] fx_op;     // bits 6:5, peek update / jump select
        logic       ofs_tgt;   // bit 4, increment goes to offset instead of pointer
        logic       ofs_sx;    // bit 3, sign-extend the offset when added to the pointer
        logic       step_sx;   // bit 2, sign-extend the step
        logic       ofs_addr;  // bit 1, address is pointer plus offset
        logic       step_sel;  // bit 0, use the step register instead of 1
    } mode_t;

    localparam logic [1:0] FX_NONE = 2'b00;
    localparam logic [1:0] FX_LOW  = 2'b01;
    localparam logic [1:0] FX_FULL = 2'b10;
    localparam logic [1:0] FX_MOVE = 2'b11;

    localparam int PORT_STREAM = 0;
    localparam int PORT_PEEK   = 1;
    localparam int FIRST_REG   = 2;

endpackage

// File: rtl/romport_wrap.sv
// Folds a raw address into the data region and adds the region base.
// Assumes the raw address exceeds the region size by less than one region,
// so a single compare-and-subtract suffices.
module romport_wrap #(
    parameter int                ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'(32'h0010_0000)
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic [ADDR_W-1:0] region_size,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] folded;

    // One conditional subtraction, then the fixed base.
    always_comb begin
        folded   = (raw_addr >= region_size) ? raw_addr - region_size : raw_addr;
        mem_addr = folded + BASE;
    end

endmodule

// File: rtl/romport_step.sv
// Computes the fetch address and the next pointer/offset for a port read.
// Assumes the caller applies the results only when a valid port read occurs.
module romport_step
    import romport_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16
) (
    input  logic              is_peek,
    input  logic              step_sel,
    input  logic              ofs_addr,
    input  logic              step_sx,
    input  logic              ofs_sx,
    input  logic              ofs_tgt,
    input  logic [1:0]        fx_op,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [OFS_W-1:0]  step,
    output logic [ADDR_W-1:0] raw_addr,
    output logic [ADDR_W-1:0] ptr_nx,
    output logic [OFS_W-1:0]  ofs_nx,
    output logic              ptr_we,
    output logic              ofs_we
);

    localparam int EXT = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_x;
    logic [ADDR_W-1:0] stp_x;
    logic [ADDR_W-1:0] sum;
    logic [OFS_W-1:0]  stp;

    // Extended operands shared by every addressing case.
    always_comb begin
        ofs_x = {{EXT{ofs_sx & ofs[OFS_W-1]}}, ofs};
        stp   = step_sel ? step : OFS_W'(1);
        stp_x = {{EXT{step_sx & stp[OFS_W-1]}}, stp};
        sum   = ptr + ofs_x;
    end

    // Selects the address and the state update for the requested port.
    always_comb begin
        raw_addr = ptr;
        ptr_nx   = ptr + stp_x;
        ofs_nx   = ofs + stp;
        ptr_we   = 1'b0;
        ofs_we   = 1'b0;
        if (is_peek) begin
            raw_addr = sum;
            if (fx_op == FX_MOVE) begin
                if (ofs_tgt) begin
                    ofs_nx = ofs + ofs;
                    ofs_we = 1'b1;
                end else begin
                    ptr_nx = sum;
                    ptr_we = 1'b1;
                end
            end
        end else if (ofs_addr) begin
            raw_addr = sum;
            ofs_nx   = ofs + OFS_W'(1);
            ofs_we   = 1'b1;
        end else if (ofs_tgt) begin
            ofs_we = 1'b1;
        end else begin
            ptr_we = 1'b1;
        end
    end

endmodule

// File: rtl/romport_jump.sv
// Computes the pointer jump caused by rewriting the offset bytes.
// Assumes the caller decides whether both offset bytes have been written.
module romport_jump
    import romport_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16
) (
    input  logic              ofs_addr,
    input  logic              ofs_sx,
    input  logic              ofs_tgt,
    input  logic [1:0]        fx_op,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [OFS_W-1:0]  ofs_new,
    output logic              jump_ok,
    output logic [ADDR_W-1:0] ptr_jump
);

    localparam int EXT = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] lo_x;
    logic [ADDR_W-1:0] full_x;

    // Mode gate and the two jump distances.
    always_comb begin
        lo_x     = {{(ADDR_W-8){ofs_sx & ofs_new[7]}}, ofs_new[7:0]};
        full_x   = {{EXT{ofs_sx & ofs_new[OFS_W-1]}}, ofs_new};
        jump_ok  = ofs_addr && !ofs_tgt && (fx_op == FX_LOW || fx_op == FX_FULL);
        ptr_jump = ptr + ((fx_op == FX_LOW) ? lo_x : full_x);
    end

endmodule

// File: rtl/romport_agen.sv
// Register file and sequencing for the ROM data port address generator.
// Holds pointer, offset, step and mode bytes; serves a streaming port and a
// peek port. Assumes one bus access per strobe cycle and a memory that answers
// in the same cycle as the address.
module romport_agen
    import romport_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter int                OFS_W       = 16,
    parameter int                REG_AW      = 4,
    parameter logic [ADDR_W-1:0] REGION_BASE = ADDR_W'(32'h0010_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_reg,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic [ADDR_W-1:0] region_size
);

    localparam int PB      = ADDR_W / 8;
    localparam int OB      = OFS_W / 8;
    localparam int RG_PTR  = FIRST_REG;
    localparam int RG_OFS  = RG_PTR + PB;
    localparam int RG_STEP = RG_OFS + OB;
    localparam int RG_MODE = RG_STEP + OB;

    logic [PB-1:0][7:0] ptr_q;
    logic [OB-1:0][7:0] ofs_q;
    logic [OB-1:0][7:0] step_q;
    mode_t              mode_q;
    logic [PB-1:0]      ptr_ok;
    logic [OB-1:0]      ofs_lat;

    logic [PB-1:0]      wr_ptr;
    logic [OB-1:0]      wr_ofs;
    logic [OB-1:0]      wr_step;
    logic               wr_mode;
    logic               unlocked;
    logic               port_rd;
    logic               is_peek;
    logic [OB-1:0][7:0] ofs_merged;
    logic [OB-1:0]      lat_after;
    logic               jump_fire;
    logic               jump_ok;
    logic [ADDR_W-1:0]  ptr_jump;
    logic [ADDR_W-1:0]  raw_addr;
    logic [ADDR_W-1:0]  ptr_nx;
    logic [OFS_W-1:0]   ofs_nx;
    logic               ptr_we;
    logic               ofs_we;
    logic [7:0]         rd_val;

    // Per-byte write decodes for the multi-byte registers.
    for (genvar g = 0; g < PB; g++) begin : g_ptr_dec
        assign wr_ptr[g] = bus_sel && bus_wr && (bus_reg == REG_AW'(RG_PTR + g));
    end
    for (genvar g = 0; g < OB; g++) begin : g_ofs_dec
        assign wr_ofs[g]  = bus_sel && bus_wr && (bus_reg == REG_AW'(RG_OFS + g));
        assign wr_step[g] = bus_sel && bus_wr && (bus_reg == REG_AW'(RG_STEP + g));
    end

    assign wr_mode  = bus_sel && bus_wr && (bus_reg == REG_AW'(RG_MODE));
    assign unlocked = &ptr_ok;
    assign is_peek  = (bus_reg == REG_AW'(PORT_PEEK));
    assign port_rd  = bus_sel && !bus_wr &&
                      (is_peek || bus_reg == REG_AW'(PORT_STREAM));
    assign mem_req  = port_rd && unlocked;

    // Offset value as it stands after the current byte write.
    always_comb begin
        ofs_merged = ofs_q;
        for (int i = 0; i < OB; i++) begin
            if (wr_ofs[i]) ofs_merged[i] = bus_wdata;
        end
    end

    assign lat_after = ofs_lat | wr_ofs;
    assign jump_fire = (|wr_ofs) && (&lat_after) && jump_ok;

    romport_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_step (
        .is_peek  (is_peek),
        .step_sel (mode_q.step_sel),
        .ofs_addr (mode_q.ofs_addr),
        .step_sx  (mode_q.step_sx),
        .ofs_sx   (mode_q.ofs_sx),
        .ofs_tgt  (mode_q.ofs_tgt),
        .fx_op    (mode_q.fx_op),
        .ptr      (ptr_q),
        .ofs      (ofs_q),
        .step     (step_q),
        .raw_addr (raw_addr),
        .ptr_nx   (ptr_nx),
        .ofs_nx   (ofs_nx),
        .ptr_we   (ptr_we),
        .ofs_we   (ofs_we)
    );

    romport_jump #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_jump (
        .ofs_addr (mode_q.ofs_addr),
        .ofs_sx   (mode_q.ofs_sx),
        .ofs_tgt  (mode_q.ofs_tgt),
        .fx_op    (mode_q.fx_op),
        .ptr      (ptr_q),
        .ofs_new  (ofs_merged),
        .jump_ok  (jump_ok),
        .ptr_jump (ptr_jump)
    );

    romport_wrap #(.ADDR_W(ADDR_W), .BASE(REGION_BASE)) u_wrap (
        .raw_addr    (raw_addr),
        .region_size (region_size),
        .mem_addr    (mem_addr)
    );

    // Read data selection for ports and register readback.
    always_comb begin
        rd_val = 8'h00;
        if (port_rd) rd_val = unlocked ? mem_rdata : 8'h00;
        for (int i = 0; i < PB; i++) begin
            if (bus_reg == REG_AW'(RG_PTR + i)) rd_val = ptr_q[i];
        end
        for (int i = 0; i < OB; i++) begin
            if (bus_reg == REG_AW'(RG_OFS + i))  rd_val = ofs_q[i];
            if (bus_reg == REG_AW'(RG_STEP + i)) rd_val = step_q[i];
        end
        if (bus_reg == REG_AW'(RG_MODE)) rd_val = mode_q;
    end

    // Register updates from bus writes, port reads and offset jumps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            ofs_q   <= '0;
            step_q  <= '0;
            mode_q  <= '0;
            ptr_ok  <= '0;
            ofs_lat <= '0;
            rdata   <= '0;
        end else begin
            for (int i = 0; i < PB; i++) begin
                if (wr_ptr[i]) begin
                    ptr_q[i]  <= bus_wdata;
                    ptr_ok[i] <= 1'b1;
                end
            end
            if (|wr_ofs) begin
                ofs_q   <= ofs_merged;
                ofs_lat <= lat_after;
                if (jump_fire) ptr_q <= ptr_jump;
            end
            for (int i = 0; i < OB; i++) begin
                if (wr_step[i]) step_q[i] <= bus_wdata;
            end
            if (wr_mode && unlocked) begin
                mode_q  <= mode_t'(bus_wdata);
                ofs_lat <= '0;
            end
            if (bus_sel && !bus_wr) rdata <= rd_val;
            if (mem_req) begin
                if (ptr_we) ptr_q <= ptr_nx;
                if (ofs_we) ofs_q <= ofs_nx;
            end
        end
    end

endmodule

// File: rtl/romport_agen_chk.sv
// Property checker for romport_agen, attached with bind.
// Assumes the register index layout of the default widths for ports 0 and 1.
module romport_agen_chk #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int REG_AW = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [REG_AW-1:0]     bus_reg,
    input logic [7:0]            rdata,
    input logic                  mem_req,
    input logic [ADDR_W/8-1:0]   ptr_ok,
    input logic [OFS_W/8-1:0]    ofs_lat,
    input logic [7:0]            mode_v,
    input logic [ADDR_W-1:0]     ptr_v,
    input logic [OFS_W-1:0]      ofs_v
);

    localparam int RG_MODE = 2 + ADDR_W / 8 + 2 * (OFS_W / 8);

    logic port_rd;
    logic peek_rd;
    logic full;

    assign port_rd = bus_sel && !bus_wr &&
                     (bus_reg == REG_AW'(0) || bus_reg == REG_AW'(1));
    assign peek_rd = bus_sel && !bus_wr && bus_reg == REG_AW'(1);
    assign full    = &ptr_ok;

    // R2: a locked port read returns 0 and moves nothing
    p_locked_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !full) |=> (rdata == 8'h00 && $stable(ptr_v) && $stable(ofs_v)));

    // R2: no memory fetch while locked, and only during a port read
    p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (port_rd && full));

    // R3: mode write before the pointer is complete is dropped
    p_mode_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_reg == REG_AW'(RG_MODE) && !full) |=> $stable(mode_v));

    // R3: an accepted mode write clears the offset latches
    p_latch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_reg == REG_AW'(RG_MODE) && full) |=> (ofs_lat == '0));

    // R4: offset-addressed streaming advances the offset by one only
    p_stream_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !peek_rd && full && mode_v[1])
        |=> ($stable(ptr_v) && ofs_v == OFS_W'($past(ofs_v) + 1'b1)));

    // R6: a peek outside the move mode leaves pointer and offset alone
    p_peek_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_rd && full && mode_v[6:5] != 2'b11) |=> ($stable(ptr_v) && $stable(ofs_v)));

endmodule

bind romport_agen romport_agen_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .REG_AW (REG_AW)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_reg (bus_reg),
    .rdata   (rdata),
    .mem_req (mem_req),
    .ptr_ok  (ptr_ok),
    .ofs_lat (ofs_lat),
    .mode_v  (mode_q),
    .ptr_v   (ptr_q),
    .ofs_v   (ofs_q)
);

// File: tb/test_romport_agen.sv
`timescale 1ns/1ps
module test_romport_agen;

    localparam logic [1:0] KW = 2'd0;  // register write
    localparam logic [1:0] KR = 2'd1;  // register read, exp = byte
    localparam logic [1:0] KP = 2'd2;  // port read, exp = folded address
    localparam logic [1:0] KZ = 2'd3;  // locked port read, expect 0

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  rg;
        logic [7:0]  dat;
        logic [23:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        '{KZ, 4'd0, 8'h00, 24'h000000, 4'd2},  // R2 stream locked
        '{KW, 4'd2, 8'h34, 24'h000000, 4'd2},
        '{KW, 4'd3, 8'h12, 24'h000000, 4'd2},
        '{KW, 4'd9, 8'h02, 24'h000000, 4'd3},  // R3 mode write dropped
        '{KR, 4'd9, 8'h00, 24'h000000, 4'd3},  // R3
        '{KZ, 4'd1, 8'h00, 24'h000000, 4'd2},  // R2 peek locked
        '{KW, 4'd4, 8'h01, 24'h000000, 4'd2},
        '{KP, 4'd0, 8'h00, 24'h111234, 4'd5},  // R5 step of 1
        '{KR, 4'd2, 8'h00, 24'h000035, 4'd5},
        '{KW, 4'd7, 8'h10, 24'h000000, 4'd5},
        '{KW, 4'd8, 8'h00, 24'h000000, 4'd5},
        '{KW, 4'd9, 8'h01, 24'h000000, 4'd5},
        '{KP, 4'd0, 8'h00, 24'h111235, 4'd5},  // R5 step register
        '{KR, 4'd2, 8'h00, 24'h000045, 4'd5},
        '{KW, 4'd8, 8'hFF, 24'h000000, 4'd5},
        '{KW, 4'd7, 8'hF0, 24'h000000, 4'd5},
        '{KW, 4'd9, 8'h05, 24'h000000, 4'd5},
        '{KP, 4'd0, 8'h00, 24'h111245, 4'd5},  // R5 signed step
        '{KR, 4'd2, 8'h00, 24'h000035, 4'd5},
        '{KR, 4'd3, 8'h00, 24'h000012, 4'd5},
        '{KW, 4'd9, 8'h11, 24'h000000, 4'd5},
        '{KP, 4'd0, 8'h00, 24'h111235, 4'd5},  // R5 step into offset
        '{KR, 4'd5, 8'h00, 24'h0000F0, 4'd5},
        '{KR, 4'd6, 8'h00, 24'h0000FF, 4'd5},
        '{KR, 4'd2, 8'h00, 24'h000035, 4'd5},
        '{KW, 4'd9, 8'h0A, 24'h000000, 4'd4},
        '{KP, 4'd0, 8'h00, 24'h111225, 4'd4},  // R4 signed offset
        '{KR, 4'd5, 8'h00, 24'h0000F1, 4'd4},
        '{KW, 4'd9, 8'h02, 24'h000000, 4'd4},
        '{KP, 4'd0, 8'h00, 24'h121226, 4'd4},  // R4 unsigned offset
        '{KP, 4'd1, 8'h00, 24'h121227, 4'd6},  // R6 plain peek
        '{KR, 4'd5, 8'h00, 24'h0000F2, 4'd6},
        '{KR, 4'd2, 8'h00, 24'h000035, 4'd6},
        '{KW, 4'd4, 8'h30, 24'h000000, 4'd8},
        '{KW, 4'd9, 8'h00, 24'h000000, 4'd8},
        '{KP, 4'd0, 8'h00, 24'h201235, 4'd8},  // R8 fold branch
        '{KR, 4'd2, 8'h00, 24'h000036, 4'd8},
        '{KW, 4'd5, 8'h00, 24'h000000, 4'd6},
        '{KW, 4'd6, 8'h01, 24'h000000, 4'd6},
        '{KW, 4'd9, 8'h60, 24'h000000, 4'd6},
        '{KP, 4'd1, 8'h00, 24'h201336, 4'd6},  // R6 peek moves pointer
        '{KR, 4'd3, 8'h00, 24'h000013, 4'd6},
        '{KR, 4'd2, 8'h00, 24'h000036, 4'd6},
        '{KW, 4'd9, 8'h70, 24'h000000, 4'd6},
        '{KP, 4'd1, 8'h00, 24'h201436, 4'd6},  // R6 peek doubles offset
        '{KR, 4'd6, 8'h00, 24'h000002, 4'd6},
        '{KR, 4'd3, 8'h00, 24'h000013, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_reg = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [23:0] region_size = 24'h200000;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    assign mem_rdata = rom_byte(mem_addr);

    romport_agen i_romport_agen (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_reg     (bus_reg),
        .bus_wdata   (bus_wdata),
        .rdata       (rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .region_size (region_size)
    );

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic do_op(input logic [1:0] k, input logic [3:0] rg, input logic [7:0] d,
                         input logic [23:0] e, input int rq);
        logic        s_req;
        logic [23:0] s_addr;
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = (k == KW);
        bus_reg   = rg;
        bus_wdata = d;
        #1;
        s_req  = mem_req;
        s_addr = mem_addr;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
        case (k)
            KR: check(rdata == e[7:0], rq, "register readback", {24'h0, rdata}, {24'h0, e[7:0]});
            KZ: begin
                check(rdata == 8'h00, rq, "locked port data", {24'h0, rdata}, 32'h0);
                check(s_req == 1'b0, rq, "locked port request", {31'h0, s_req}, 32'h0);
            end
            KP: begin
                check(s_req && s_addr == e, rq, "port address", {7'h0, s_req, s_addr}, {8'h01, e});
                check(rdata == rom_byte(e), rq, "port data", {24'h0, rdata}, {24'h0, rom_byte(e)});
            end
            default: ;
        endcase
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs right after reset
        check(rdata == 8'h00, 1, "rdata after reset", {24'h0, rdata}, 32'h0);
        do_op(KR, 4'd2, 8'h00, 24'h0, 1);  // R1
        do_op(KR, 4'd9, 8'h00, 24'h0, 1);  // R1

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].kind, VEC[i].rg, VEC[i].dat, VEC[i].exp, int'(VEC[i].req));
        end

        // R7: offset-write jumps; pointer is 0x301336, offset 0x0200 here
        do_op(KW, 4'd9, 8'h22, 24'h0, 7);
        do_op(KW, 4'd5, 8'h80, 24'h0, 7);
        do_op(KR, 4'd2, 8'h00, 24'h000036, 7);   // R7 one byte only: no jump
        do_op(KW, 4'd6, 8'h00, 24'h0, 7);
        do_op(KR, 4'd2, 8'h00, 24'h0000B6, 7);   // R7 +0x80 unsigned
        do_op(KW, 4'd9, 8'h2A, 24'h0, 7);
        do_op(KW, 4'd6, 8'h12, 24'h0, 7);
        do_op(KW, 4'd5, 8'hF0, 24'h0, 7);
        do_op(KR, 4'd2, 8'h00, 24'h0000A6, 7);   // R7 low byte sign-extended
        do_op(KW, 4'd5, 8'h01, 24'h0, 7);
        do_op(KR, 4'd2, 8'h00, 24'h0000A7, 7);   // R7 latches stay set
        do_op(KW, 4'd9, 8'h42, 24'h0, 7);
        do_op(KW, 4'd5, 8'h00, 24'h0, 7);
        do_op(KW, 4'd6, 8'h01, 24'h0, 7);
        do_op(KR, 4'd3, 8'h00, 24'h000014, 7);   // R7 full offset added
        do_op(KR, 4'd2, 8'h00, 24'h0000A7, 7);
        do_op(KW, 4'd9, 8'h52, 24'h0, 7);
        do_op(KW, 4'd5, 8'h00, 24'h0, 7);
        do_op(KW, 4'd6, 8'h01, 24'h0, 7);
        do_op(KR, 4'd3, 8'h00, 24'h000014, 7);   // R7 bit 4 blocks the jump

        // R10: 24-bit pointer wrap and 16-bit offset wrap
        do_op(KW, 4'd2, 8'hFF, 24'h0, 10);
        do_op(KW, 4'd3, 8'hFF, 24'h0, 10);
        do_op(KW, 4'd4, 8'hFF, 24'h0, 10);
        do_op(KW, 4'd9, 8'h00, 24'h0, 10);
        do_op(KP, 4'd0, 8'h00, 24'hEFFFFF, 8);   // R8 fold of 0xFFFFFF
        do_op(KR, 4'd4, 8'h00, 24'h000000, 10);  // R10
        do_op(KR, 4'd2, 8'h00, 24'h000000, 10);
        do_op(KW, 4'd9, 8'h02, 24'h0, 10);
        do_op(KW, 4'd5, 8'hFF, 24'h0, 10);
        do_op(KW, 4'd6, 8'hFF, 24'h0, 10);
        do_op(KP, 4'd0, 8'h00, 24'h10FFFF, 10);  // R10
        do_op(KR, 4'd6, 8'h00, 24'h000000, 10);
        do_op(KR, 4'd5, 8'h00, 24'h000000, 10);

        // R9: unused index and mode readback
        do_op(KR, 4'd10, 8'h00, 24'h000000, 9);
        do_op(KR, 4'd9, 8'h00, 24'h000002, 9);
        do_op(KR, 4'd8, 8'h00, 24'h0000FF, 9);

        // R1 and R2: reset in mid-run clears state and relocks the ports
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(rdata == 8'h00, 1, "rdata after second reset", {24'h0, rdata}, 32'h0);
        do_op(KR, 4'd3, 8'h00, 24'h0, 1);   // R1
        do_op(KR, 4'd7, 8'h00, 24'h0, 1);   // R1
        do_op(KZ, 4'd0, 8'h00, 24'h0, 2);   // R2
        do_op(KW, 4'd9, 8'h02, 24'h0, 3);
        do_op(KR, 4'd9, 8'h00, 24'h0, 3);   // R3

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule